// File: doc/BRIEF.md
# Programmable Parallel Peripheral Interface

This block gives a host processor three 8-bit parallel ports, called A, B and C, behind a small register map. The host uses an 8-bit data bus that is split into separate input and output halves, two address bits, an active-low chip select, and active-low read and write strobes. A control word register sets the direction and operating mode of two groups. Group A covers port A and the upper half of port C. Group B covers port B and the lower half of port C. The same register address also takes commands that set or clear one port C bit.

In basic mode a port is a plain latch: output latches drive the pins, and input pins are read directly. In strobed mode a port exchanges data with a peripheral through a handshake. Some port C lines then stop being ordinary I/O and carry the strobe or acknowledge from the peripheral, a buffer status line and an interrupt request. Each strobed port has an interrupt enable, which is the latch of its strobe or acknowledge bit in port C. Software sets or clears that latch with the single-bit command. All logic runs on one clock, and the bus strobes are sampled on that clock.

Top module: `par_io_top`

## Requirements
- R1: After reset every port is an input (paOe=0, pbOe=0, pcOe=8'h00), both groups are in basic mode and every output latch holds 0.
- R2: addr 0 selects port A, 1 port B, 2 port C and 3 the control register. A write is taken once, on the first clock with csN=0 and wrN=0, and has no effect while csN=1. dataOe is 1, and dataOut carries the selected value, only while csN=0 and rdN=0. A read of address 3 returns 8'h00.
- R3: A control write with bit 7 set is a mode word. Bits 6..5 give the group A mode (01 strobed, 00 basic). Bit 4 gives the port A direction, bit 3 the upper C direction, bit 2 the group B mode (1 strobed), bit 1 the port B direction and bit 0 the lower C direction. A direction bit of 1 means input, and paOe, pbOe and pcOe follow these bits.
- R4: In basic mode an output port drives its latch onto its pins and reads back the latch. An input port reads its pins as they are at that moment.
- R5: Every mode word clears the port A, B and C output latches to 0.
- R6: A control write with bit 7 clear sets port C latch bit [3:1] to the value of bit 0. The other seven latch bits keep their values.
- R7: The two port C halves take their directions separately. A port C read returns the pin for each input bit and the latch for each output bit.
- R8: Group A strobed input uses these lines: PC4 is the strobe (active low), PC5 is the buffer-full flag (active high) and PC3 is the interrupt request. A strobe at 0 captures port A and sets PC5. The rising edge of the strobe sets PC3 if the PC4 latch is 1. A completed read of port A returns the captured data and clears PC5 and PC3.
- R9: Group A strobed output uses these lines: PC7 is the buffer-full line (active low), PC6 is the acknowledge (active low) and PC3 is the interrupt request. A port A write drives PC7 to 0 and clears PC3. An acknowledge at 0 returns PC7 to 1. The rising edge of the acknowledge sets PC3 if the PC6 latch is 1.
- R10: Group B strobed mode uses these lines: PC2 is the strobe or acknowledge, PC1 is the buffer-full line (active high for input, active low for output), PC0 is the interrupt request, and the PC2 latch is the interrupt enable. The rules are otherwise the same as in R8 and R9, applied to port B.
- R11: In strobed mode the handshake outputs are always driven, the strobe or acknowledge input is never driven, and a port C write does not change them. A port C read returns the status on the handshake outputs and the enable latch on the strobe or acknowledge bit.
- R12: A group A mode field of 10 or 11 acts as basic mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| dataIn | input | 8 | Host write data |
| dataOut | output | 8 | Host read data |
| dataOe | output | 1 | Host data bus drive enable |
| paIn | input | 8 | Port A pins in |
| paOut | output | 8 | Port A pins out |
| paOe | output | 1 | Port A drive enable |
| pbIn | input | 8 | Port B pins in |
| pbOut | output | 8 | Port B pins out |
| pbOe | output | 1 | Port B drive enable |
| pcIn | input | 8 | Port C pins in |
| pcOut | output | 8 | Port C pins out |
| pcOe | output | 8 | Port C per-bit drive enable |

## Verification
Basic mode is exercised with fixed, distinct pin values on each port, and with mode words that make every port an input, every port an output, and mixed direction halves. These cases tell a live pin read from a latch read back, and show whether the two port C halves are decoded separately. Single-bit commands set and clear separate bits so that a wrong select field or a wrong bit width is visible. Handshake tests change the port data after the strobe rises and run with the interrupt enable both on and off. These tests separate the data captured at the strobe from the live pins, and a gated interrupt from one that is always raised.

// File: rtl/par_io_pkg.sv
`timescale 1ns/1ps
package par_io_pkg;
  localparam int DataW = 8;
  localparam int HalfW = DataW / 2;
  localparam int SelW  = 2;
  localparam int BitSelW = $clog2(DataW);

  typedef enum logic [SelW-1:0] {
    SelA   = 2'd0,
    SelB   = 2'd1,
    SelC   = 2'd2,
    SelCtl = 2'd3
  } sel_e;

  // Port C bit roles in strobed mode
  localparam int PcIntrB = 0;
  localparam int PcIbfB  = 1;
  localparam int PcStbB  = 2;
  localparam int PcIntrA = 3;
  localparam int PcStbA  = 4;
  localparam int PcIbfA  = 5;
  localparam int PcAckA  = 6;
  localparam int PcObfA  = 7;

  typedef struct packed {
    logic aStrobed;
    logic aIn;
    logic cHiIn;
    logic bStrobed;
    logic bIn;
    logic cLoIn;
  } cfg_t;

  typedef struct packed {
    logic               modeSet;
    logic               bitOp;
    logic [BitSelW-1:0] bitSel;
    logic               bitVal;
    logic               wrA;
    logic               wrB;
    logic               wrC;
    logic               rdDoneA;
    logic               rdDoneB;
  } strb_t;
endpackage

// File: rtl/par_io_ctrl.sv
`timescale 1ns/1ps
module par_io_ctrl
  import par_io_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             csN,
  input  logic             rdN,
  input  logic             wrN,
  input  logic [SelW-1:0]  addr,
  input  logic [DataW-1:0] dataIn,
  output cfg_t             cfg,
  output strb_t            strb,
  output sel_e             rdSel,
  output logic             rdActive
);
  logic wrNQ;
  logic rdActiveQ;
  sel_e rdSelQ;
  logic wrEdge;
  sel_e sel;

  assign sel      = sel_e'(addr);
  assign wrEdge   = !csN && !wrN && wrNQ;
  assign rdActive = !csN && !rdN;
  assign rdSel    = sel;

  always_comb begin
    strb         = '0;
    strb.modeSet = wrEdge && (sel == SelCtl) && dataIn[DataW-1];
    strb.bitOp   = wrEdge && (sel == SelCtl) && !dataIn[DataW-1];
    strb.bitSel  = dataIn[BitSelW:1];
    strb.bitVal  = dataIn[0];
    strb.wrA     = wrEdge && (sel == SelA);
    strb.wrB     = wrEdge && (sel == SelB);
    strb.wrC     = wrEdge && (sel == SelC);
    strb.rdDoneA = rdActiveQ && !rdActive && (rdSelQ == SelA);
    strb.rdDoneB = rdActiveQ && !rdActive && (rdSelQ == SelB);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrNQ      <= 1'b1;
      rdActiveQ <= 1'b0;
      rdSelQ    <= SelA;
      cfg       <= '{aStrobed: 1'b0, aIn: 1'b1, cHiIn: 1'b1,
                     bStrobed: 1'b0, bIn: 1'b1, cLoIn: 1'b1};
    end else begin
      wrNQ      <= wrN || csN;
      rdActiveQ <= rdActive;
      rdSelQ    <= sel;
      if (strb.modeSet) begin
        cfg.aStrobed <= (dataIn[6:5] == 2'b01);
        cfg.aIn      <= dataIn[4];
        cfg.cHiIn    <= dataIn[3];
        cfg.bStrobed <= dataIn[2];
        cfg.bIn      <= dataIn[1];
        cfg.cLoIn    <= dataIn[0];
      end
    end
  end
endmodule

// File: rtl/par_io_hshk.sv
`timescale 1ns/1ps
module par_io_hshk (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic active,
  input  logic dirIn,
  input  logic pinN,
  input  logic inte,
  input  logic rdDone,
  input  logic wrDone,
  output logic full,
  output logic intr,
  output logic capture
);
  logic pinQ;
  logic pinRise;

  assign pinRise = pinN && !pinQ;
  assign capture = active && dirIn && !pinN;

  always_ff @(posedge clk) begin
    if (rst) begin
      pinQ <= 1'b1;
      full <= 1'b0;
      intr <= 1'b0;
    end else begin
      pinQ <= pinN;
      if (clr || !active) begin
        full <= 1'b0;
        intr <= 1'b0;
      end else if (dirIn) begin
        if (!pinN)       full <= 1'b1;
        else if (rdDone) full <= 1'b0;
        if (rdDone)                        intr <= 1'b0;
        else if (pinRise && inte && full)  intr <= 1'b1;
      end else begin
        if (wrDone)      full <= 1'b1;
        else if (!pinN)  full <= 1'b0;
        if (wrDone)                        intr <= 1'b0;
        else if (pinRise && inte && !full) intr <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/par_io_data.sv
`timescale 1ns/1ps
module par_io_data
  import par_io_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  cfg_t             cfg,
  input  strb_t            strb,
  input  logic [DataW-1:0] wrData,
  input  sel_e             rdSel,
  input  logic [DataW-1:0] paIn,
  input  logic [DataW-1:0] pbIn,
  input  logic [DataW-1:0] pcIn,
  output logic [DataW-1:0] paOut,
  output logic             paOe,
  output logic [DataW-1:0] pbOut,
  output logic             pbOe,
  output logic [DataW-1:0] pcOut,
  output logic [DataW-1:0] pcOe,
  output logic [DataW-1:0] rdData
);
  logic [DataW-1:0] aLatch, bLatch, cLatch, aCap, bCap;
  logic [DataW-1:0] hsMask, hsDrive, hsVal, pcDirIn, rdC;
  logic fullA, intrA, capA, fullB, intrB, capB;
  logic pinA, inteA, inteB;

  assign pinA  = cfg.aIn ? pcIn[PcStbA]   : pcIn[PcAckA];
  assign inteA = cfg.aIn ? cLatch[PcStbA] : cLatch[PcAckA];
  assign inteB = cLatch[PcStbB];

  par_io_hshk u_hsA (
    .clk(clk), .rst(rst), .clr(strb.modeSet), .active(cfg.aStrobed),
    .dirIn(cfg.aIn), .pinN(pinA), .inte(inteA), .rdDone(strb.rdDoneA),
    .wrDone(strb.wrA), .full(fullA), .intr(intrA), .capture(capA)
  );

  par_io_hshk u_hsB (
    .clk(clk), .rst(rst), .clr(strb.modeSet), .active(cfg.bStrobed),
    .dirIn(cfg.bIn), .pinN(pcIn[PcStbB]), .inte(inteB), .rdDone(strb.rdDoneB),
    .wrDone(strb.wrB), .full(fullB), .intr(intrB), .capture(capB)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      aLatch <= '0;
      bLatch <= '0;
      cLatch <= '0;
      aCap   <= '0;
      bCap   <= '0;
    end else begin
      if (capA) aCap <= paIn;
      if (capB) bCap <= pbIn;
      if (strb.modeSet) begin
        aLatch <= '0;
        bLatch <= '0;
        cLatch <= '0;
      end else begin
        if (strb.wrA) aLatch <= wrData;
        if (strb.wrB) bLatch <= wrData;
        if (strb.wrC)        cLatch <= wrData;
        else if (strb.bitOp) cLatch[strb.bitSel] <= strb.bitVal;
      end
    end
  end

  // Handshake overlay on port C
  always_comb begin
    hsMask  = '0;
    hsDrive = '0;
    hsVal   = '0;
    if (cfg.aStrobed) begin
      hsMask[PcIntrA]  = 1'b1;
      hsDrive[PcIntrA] = 1'b1;
      hsVal[PcIntrA]   = intrA;
      if (cfg.aIn) begin
        hsMask[PcStbA]  = 1'b1;
        hsMask[PcIbfA]  = 1'b1;
        hsDrive[PcIbfA] = 1'b1;
        hsVal[PcIbfA]   = fullA;
      end else begin
        hsMask[PcAckA]  = 1'b1;
        hsMask[PcObfA]  = 1'b1;
        hsDrive[PcObfA] = 1'b1;
        hsVal[PcObfA]   = !fullA;
      end
    end
    if (cfg.bStrobed) begin
      hsMask[PcIntrB]  = 1'b1;
      hsDrive[PcIntrB] = 1'b1;
      hsVal[PcIntrB]   = intrB;
      hsMask[PcStbB]   = 1'b1;
      hsMask[PcIbfB]   = 1'b1;
      hsDrive[PcIbfB]  = 1'b1;
      hsVal[PcIbfB]    = cfg.bIn ? fullB : !fullB;
    end
  end

  assign pcDirIn = {{HalfW{cfg.cHiIn}}, {HalfW{cfg.cLoIn}}};
  assign pcOut   = hsVal | (~hsDrive & cLatch);
  assign pcOe    = hsDrive | (~hsMask & ~pcDirIn);
  assign rdC     = (~hsMask & pcDirIn & pcIn) | (~(~hsMask & pcDirIn) & pcOut);

  assign paOut = aLatch;
  assign pbOut = bLatch;
  assign paOe  = !cfg.aIn;
  assign pbOe  = !cfg.bIn;

  always_comb begin
    case (rdSel)
      SelA:    rdData = (cfg.aStrobed && cfg.aIn) ? aCap : (cfg.aIn ? paIn : aLatch);
      SelB:    rdData = (cfg.bStrobed && cfg.bIn) ? bCap : (cfg.bIn ? pbIn : bLatch);
      SelC:    rdData = rdC;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/par_io_top.sv
`timescale 1ns/1ps
module par_io_top
  import par_io_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             csN,
  input  logic             rdN,
  input  logic             wrN,
  input  logic [SelW-1:0]  addr,
  input  logic [DataW-1:0] dataIn,
  output logic [DataW-1:0] dataOut,
  output logic             dataOe,
  input  logic [DataW-1:0] paIn,
  output logic [DataW-1:0] paOut,
  output logic             paOe,
  input  logic [DataW-1:0] pbIn,
  output logic [DataW-1:0] pbOut,
  output logic             pbOe,
  input  logic [DataW-1:0] pcIn,
  output logic [DataW-1:0] pcOut,
  output logic [DataW-1:0] pcOe
);
  cfg_t             cfg;
  strb_t            strb;
  sel_e             rdSel;
  logic             rdActive;
  logic [DataW-1:0] rdData;

  par_io_ctrl u_ctrl (
    .clk(clk), .rst(rst), .csN(csN), .rdN(rdN), .wrN(wrN), .addr(addr),
    .dataIn(dataIn), .cfg(cfg), .strb(strb), .rdSel(rdSel), .rdActive(rdActive)
  );

  par_io_data u_data (
    .clk(clk), .rst(rst), .cfg(cfg), .strb(strb), .wrData(dataIn), .rdSel(rdSel),
    .paIn(paIn), .pbIn(pbIn), .pcIn(pcIn), .paOut(paOut), .paOe(paOe),
    .pbOut(pbOut), .pbOe(pbOe), .pcOut(pcOut), .pcOe(pcOe), .rdData(rdData)
  );

  assign dataOut = rdActive ? rdData : '0;
  assign dataOe  = rdActive;
endmodule

// File: rtl/par_io_checker.sv
`timescale 1ns/1ps
module par_io_checker
  import par_io_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             csN,
  input logic             dataOe,
  input logic [DataW-1:0] paOut,
  input logic [DataW-1:0] pbOut,
  input logic [DataW-1:0] pcIn,
  input logic [DataW-1:0] pcOut,
  input logic             aStrobed,
  input logic             aIn,
  input logic             bStrobed,
  input logic             bIn,
  input logic             modeSet,
  input logic             bitOp,
  input logic             wrA,
  input logic             rdDoneA
);
  // R2
  a_r2_no_drive_unselected: assert property (@(posedge clk) disable iff (rst)
    csN |-> !dataOe);

  // R5
  a_r5_mode_clears: assert property (@(posedge clk) disable iff (rst)
    modeSet |=> (paOut == '0) && (pbOut == '0));

  // R6
  a_r6_single_bit: assert property (@(posedge clk) disable iff (rst)
    bitOp && !aStrobed && !bStrobed |=> $countones(pcOut ^ $past(pcOut)) <= 1);

  // R8
  a_r8_ibf_on_strobe: assert property (@(posedge clk) disable iff (rst)
    aStrobed && aIn && !pcIn[PcStbA] && !modeSet |=> pcOut[PcIbfA]);

  // R8
  a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
    rdDoneA && aStrobed && aIn && pcIn[PcStbA] && !modeSet
      |=> !pcOut[PcIbfA] && !pcOut[PcIntrA]);

  // R9
  a_r9_obf_on_write: assert property (@(posedge clk) disable iff (rst)
    wrA && aStrobed && !aIn |=> !pcOut[PcObfA]);

  // R10
  a_r10_ibf_b_on_strobe: assert property (@(posedge clk) disable iff (rst)
    bStrobed && bIn && !pcIn[PcStbB] && !modeSet |=> pcOut[PcIbfB]);
endmodule

bind par_io_top par_io_checker u_chk (
  .clk(clk), .rst(rst), .csN(csN), .dataOe(dataOe), .paOut(paOut), .pbOut(pbOut),
  .pcIn(pcIn), .pcOut(pcOut), .aStrobed(cfg.aStrobed), .aIn(cfg.aIn),
  .bStrobed(cfg.bStrobed), .bIn(cfg.bIn), .modeSet(strb.modeSet),
  .bitOp(strb.bitOp), .wrA(strb.wrA), .rdDoneA(strb.rdDoneA)
);

// File: tb/par_io_top_tb.sv
`timescale 1ns/1ps
module par_io_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] dataIn = 8'h00;
  logic [7:0] dataOut, paOut, pbOut, pcOut, pcOe;
  logic dataOe, paOe, pbOe;
  logic [7:0] paIn = 8'h5A, pbIn = 8'hC3, pcIn = 8'h96;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  par_io_top u_dut (
    .clk(clk), .rst(rst), .csN(csN), .rdN(rdN), .wrN(wrN), .addr(addr),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .paIn(paIn), .paOut(paOut), .paOe(paOe),
    .pbIn(pbIn), .pbOut(pbOut), .pbOe(pbOe),
    .pcIn(pcIn), .pcOut(pcOut), .pcOe(pcOe)
  );

  typedef struct packed {
    logic       wr;
    logic [1:0] adr;
    logic [7:0] data;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NumVec = 16;
  localparam vec_t Vecs [NumVec] = '{
    '{1'b1, 2'd3, 8'h9B, 8'h00, 4'd3},  // R3 all inputs
    '{1'b0, 2'd0, 8'h00, 8'h5A, 4'd4},  // R4 live pins A
    '{1'b0, 2'd1, 8'h00, 8'hC3, 4'd4},  // R4 live pins B
    '{1'b0, 2'd2, 8'h00, 8'h96, 4'd7},  // R7 both C halves in
    '{1'b1, 2'd3, 8'h80, 8'h00, 4'd3},  // R3 all outputs
    '{1'b1, 2'd0, 8'h11, 8'h00, 4'd4},
    '{1'b0, 2'd0, 8'h00, 8'h11, 4'd4},  // R4 latch read back
    '{1'b1, 2'd1, 8'h22, 8'h00, 4'd4},
    '{1'b0, 2'd1, 8'h00, 8'h22, 4'd4},
    '{1'b1, 2'd2, 8'h33, 8'h00, 4'd7},
    '{1'b0, 2'd2, 8'h00, 8'h33, 4'd7},
    '{1'b1, 2'd3, 8'h8A, 8'h00, 4'd3},  // A out, C hi in, B in, C lo out
    '{1'b0, 2'd0, 8'h00, 8'h00, 4'd5},  // R5 latch cleared
    '{1'b0, 2'd1, 8'h00, 8'hC3, 4'd3},
    '{1'b0, 2'd2, 8'h00, 8'h90, 4'd7},  // R7 mixed halves
    '{1'b0, 2'd3, 8'h00, 8'h00, 4'd2}   // R2 control read is zero
  };

  task automatic check(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d, input logic sel);
    @(negedge clk);
    csN = !sel; wrN = 1'b0; addr = a; dataIn = d;
    @(negedge clk);
    wrN = 1'b1; csN = 1'b1;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    csN = 1'b0; rdN = 1'b0; addr = a;
    #2 d = dataOut;
    @(negedge clk);
    rdN = 1'b1; csN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got %h expected %h", 8'h00, 8'h01);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!paOe && !pbOe && pcOe == 8'h00, "R1", pcOe, 8'h00);
    check(paOut == 8'h00 && pbOut == 8'h00, "R1", paOut, 8'h00);
    check(pcOut == 8'h00, "R1", pcOut, 8'h00);
    busRead(2'd0, rd);
    check(rd == 8'h5A, "R1", rd, 8'h5A);

    for (int i = 0; i < NumVec; i++) begin
      if (Vecs[i].wr) busWrite(Vecs[i].adr, Vecs[i].data, 1'b1);
      else begin
        busRead(Vecs[i].adr, rd);
        check(rd == Vecs[i].exp, $sformatf("R%0d vec %0d", Vecs[i].req, i), rd, Vecs[i].exp);
      end
    end

    // R2 unselected write and read
    busWrite(2'd0, 8'h77, 1'b0);
    check(paOut == 8'h00, "R2", paOut, 8'h00);
    @(negedge clk); rdN = 1'b0; #2;
    check(!dataOe, "R2", {7'd0, dataOe}, 8'h00);
    rdN = 1'b1;

    // R3 enables follow mode word
    busWrite(2'd3, 8'h80, 1'b1);
    check(paOe && pbOe && pcOe == 8'hFF, "R3", pcOe, 8'hFF);

    // R6 single bit commands
    busWrite(2'd2, 8'h00, 1'b1);
    busWrite(2'd3, 8'h0B, 1'b1);
    check(pcOut == 8'h20, "R6", pcOut, 8'h20);
    busWrite(2'd3, 8'h01, 1'b1);
    check(pcOut == 8'h21, "R6", pcOut, 8'h21);
    busWrite(2'd3, 8'h0A, 1'b1);
    check(pcOut == 8'h01, "R6", pcOut, 8'h01);

    // R12 mode field 10 behaves as basic
    busWrite(2'd3, 8'hC0, 1'b1);
    busWrite(2'd0, 8'h44, 1'b1);
    check(paOut == 8'h44 && pcOe == 8'hFF, "R12", paOut, 8'h44);

    // R8 group A strobed input
    pcIn = 8'h54;
    paIn = 8'hA5;
    busWrite(2'd3, 8'hB0, 1'b1);
    busWrite(2'd3, 8'h09, 1'b1);
    @(negedge clk); pcIn[4] = 1'b0;
    @(negedge clk);
    check(pcOut[5] && !pcOut[3] && pcOe[5] && !pcOe[4], "R8", pcOut, 8'h30);
    pcIn[4] = 1'b1; paIn = 8'h00;
    @(negedge clk);
    check(pcOut[3] == 1'b1, "R8", pcOut, 8'h38);
    busRead(2'd2, rd);
    check(rd == 8'h38, "R11", rd, 8'h38);
    busRead(2'd0, rd);
    check(rd == 8'hA5, "R8", rd, 8'hA5);
    check(!pcOut[5] && !pcOut[3], "R8", pcOut, 8'h10);
    busWrite(2'd3, 8'h08, 1'b1);
    @(negedge clk); pcIn[4] = 1'b0;
    @(negedge clk); pcIn[4] = 1'b1;
    @(negedge clk);
    check(pcOut[5] && !pcOut[3], "R8", pcOut, 8'h20);

    // R9 group A strobed output
    busWrite(2'd3, 8'hA0, 1'b1);
    check(pcOut[7] && !paOe == 1'b0, "R9", pcOut, 8'h80);
    busWrite(2'd3, 8'h0D, 1'b1);
    busWrite(2'd0, 8'h3C, 1'b1);
    check(!pcOut[7] && paOut == 8'h3C, "R9", pcOut, 8'h40);
    @(negedge clk); pcIn[6] = 1'b0;
    @(negedge clk);
    check(pcOut[7] && !pcOut[3], "R9", pcOut, 8'hC0);
    pcIn[6] = 1'b1;
    @(negedge clk);
    check(pcOut[3] == 1'b1, "R9", pcOut, 8'hC8);
    busWrite(2'd0, 8'h00, 1'b1);
    check(!pcOut[3] && !pcOut[7], "R9", pcOut, 8'h40);

    // R10 group B strobed input
    pbIn = 8'h69;
    busWrite(2'd3, 8'h86, 1'b1);
    busWrite(2'd3, 8'h05, 1'b1);
    @(negedge clk); pcIn[2] = 1'b0;
    @(negedge clk);
    check(pcOut[1] && !pcOut[0], "R10", pcOut, 8'h06);
    pcIn[2] = 1'b1; pbIn = 8'h00;
    @(negedge clk);
    check(pcOut[0] == 1'b1, "R10", pcOut, 8'h07);
    busRead(2'd1, rd);
    check(rd == 8'h69, "R10", rd, 8'h69);
    check(pcOut[1:0] == 2'b00, "R10", pcOut, 8'h04);

    // R11 port C write leaves handshake lines alone
    busWrite(2'd2, 8'hFF, 1'b1);
    check(pcOut == 8'hFC, "R11", pcOut, 8'hFC);
    check(pcOe == 8'hFB, "R11", pcOe, 8'hFB);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule